// File: doc/BRIEF.md
# Card Configuration Option Register and Task-File Decoder

This block keeps the configuration option byte of a removable storage card and turns host accesses into task-file register selects. The byte lives in attribute memory at offset 0x200. Its top bit holds the card core in reset. The next bit chooses how interrupts are shaped. The low six bits pick one of four address layouts for the task file: a memory window, a contiguous I/O window, or one of two legacy I/O port sets.

The host drives the address, a two-bit space qualifier, write data and a read or write strobe. The block answers configuration reads with no wait cycle. For any other strobed access it reports whether a task-file register was hit, together with a 4-bit register index. A one-stage interrupt shaper sits between the core's request line and the host interrupt output. It emits either a one-cycle pulse or a copy of the request level.

Top module: `cfg_option_decoder`

## Requirements
- R1: After a synchronous hard reset (rst_n low at a clock edge), the stored byte is 0x00, soft_rst is 0, level_mode is 0 and irq_out is 0.
- R2: A write strobe with host_space = 2'b01 (attribute) at address 0x200 stores host_wdata at that clock edge. A read strobe there sets host_rd_hit and returns the stored byte on host_rdata in the same cycle. Any other address or space neither writes the byte nor hits: host_rd_hit is 0 and host_rdata is 0x00.
- R3: Bit 7 of the byte drives soft_rst. Once set, it stays set until the host writes a byte with bit 7 = 0 or a hard reset occurs.
- R4: A write with bit 7 = 1 clears bit 6 and the index bits 5:0, so the byte reads back as 0x80 whatever the other written bits were.
- R5: Bit 6 drives level_mode. In level mode, irq_out equals irq_req delayed by one clock.
- R6: In pulse mode (bit 6 = 0), each 0-to-1 change of irq_req gives irq_out = 1 for exactly one clock, one clock after the change.
- R7: Index 0 (memory-mapped) selects the task file only in common memory (host_space = 2'b00), at 0x000..0x00F and at the mirror 0x400..0x7FF, with tf_idx = address bits 3:0.
- R8: Index 1 (contiguous I/O) selects the task file for any I/O access (host_space = 2'b10), with tf_idx = address bits 3:0. Common memory is not decoded.
- R9: Index 2 (primary I/O) selects I/O addresses 0x1F0..0x1F7 as tf_idx 0..7, 0x3F6 as 0xE and 0x3F7 as 0xF. No other address is decoded.
- R10: Index 3 (secondary I/O) selects I/O addresses 0x170..0x177 as tf_idx 0..7, 0x376 as 0xE and 0x377 as 0xF. No other address is decoded.
- R11: Any index value above 3 behaves as index 0: memory-mapped windows only, no I/O decoding.
- R12: tf_sel is 1 only while host_we or host_re is 1. It is never 1 for attribute-space accesses. While tf_sel is 0, tf_idx is 0.
- R13: While soft_rst is 1, irq_out is 0 from the next clock on, whatever irq_req does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| host_space | input | 2 | Access space: 00 common memory, 01 attribute, 10 I/O, 11 none |
| host_addr | input | ADDR_W (11) | Host byte address |
| host_wdata | input | 8 | Write data |
| host_we | input | 1 | Write strobe |
| host_re | input | 1 | Read strobe |
| host_rdata | output | 8 | Configuration byte on a read hit, otherwise 0 |
| host_rd_hit | output | 1 | Read addressed the configuration byte |
| irq_req | input | 1 | Interrupt request from the card core |
| soft_rst | output | 1 | Reset hold to the card core |
| level_mode | output | 1 | 1 = level interrupts, 0 = pulse interrupts |
| irq_out | output | 1 | Shaped interrupt to the host |
| tf_sel | output | 1 | Access hits a task-file register |
| tf_idx | output | 4 | Task-file register index |

## Verification
The bench uses the default parameters: an 11-bit address, mirror bit 10, and the legacy bases 0x1F0/0x3F6 and 0x170/0x376. With an 11-bit address the whole 0x400..0x7FF mirror can be reached. Addresses just outside each window can also be driven (0x010, 0x3FF, 0x1F8, 0x3F5, 0x178), so the edge of every window is tested from both sides. A table walks all four layouts plus two unlisted index values, and directed tests cover the sticky soft-reset clearing and both interrupt shapes.

// File: rtl/cfgdec_pkg.sv
// Shared encodings for the configuration option decoder.
// Assumes a two-bit space qualifier supplied by the host interface.
package cfgdec_pkg;

    typedef enum logic [1:0] {
        SP_COMMON = 2'b00,
        SP_ATTR   = 2'b01,
        SP_IO     = 2'b10,
        SP_NONE   = 2'b11
    } space_e;

    typedef enum logic [1:0] {
        MAP_MEM    = 2'd0,
        MAP_CONTIG = 2'd1,
        MAP_PRI    = 2'd2,
        MAP_SEC    = 2'd3
    } map_e;

    localparam int unsigned INDEX_W = 6;
    localparam int unsigned TF_W    = 4;

    // Turn the six-bit index field into a layout; unlisted values fall back to memory.
    function automatic map_e index_to_map(input logic [INDEX_W-1:0] ix);
        map_e m;
        case (ix)
            6'd1:    m = MAP_CONTIG;
            6'd2:    m = MAP_PRI;
            6'd3:    m = MAP_SEC;
            default: m = MAP_MEM;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cfgdec_opt_reg.sv
// Configuration option byte: holds the reset hold bit, interrupt style bit
// and layout index. Assumes single-cycle write strobes; reads are combinational.
module cfgdec_opt_reg
    import cfgdec_pkg::*;
#(
    parameter int unsigned ADDR_W   = 11,
    parameter int unsigned CFG_ADDR = 'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        space,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              we,
    input  logic              re,
    output logic [7:0]        rdata,
    output logic              rd_hit,
    output logic              hold_rst,
    output logic              level_sel,
    output map_e              map_mode
);
    localparam logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(CFG_ADDR);

    logic                 hold_q;
    logic                 level_q;
    logic [INDEX_W-1:0]   index_q;
    logic                 addr_match;

    // Address compare: attribute space, exact offset.
    always_comb begin
        addr_match = (space == SP_ATTR) && (addr == REG_ADDR);
    end

    // Byte update: a set hold bit forces the other fields to defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= 1'b0;
            level_q <= 1'b0;
            index_q <= '0;
        end else if (we && addr_match) begin
            hold_q <= wdata[7];
            if (wdata[7]) begin
                level_q <= 1'b0;
                index_q <= '0;
            end else begin
                level_q <= wdata[6];
                index_q <= wdata[INDEX_W-1:0];
            end
        end
    end

    // Read path: return the stored byte on a hit, zero otherwise.
    always_comb begin
        rd_hit = re && addr_match;
        rdata  = rd_hit ? {hold_q, level_q, index_q} : 8'h00;
    end

    // Field outputs to the rest of the block.
    always_comb begin
        hold_rst  = hold_q;
        level_sel = level_q;
        map_mode  = index_to_map(index_q);
    end

endmodule

// File: rtl/cfgdec_tf_decode.sv
// Task-file address decoder for the four layouts. Assumes byte addresses of
// ADDR_W bits; legacy windows are eight ports plus a two-port alternate pair.
module cfgdec_tf_decode
    import cfgdec_pkg::*;
#(
    parameter int unsigned ADDR_W     = 11,
    parameter int unsigned MIRROR_BIT = 10,
    parameter bit          MIRROR_EN  = 1'b1,
    parameter int unsigned PRI_BASE   = 'h1F0,
    parameter int unsigned PRI_ALT    = 'h3F6,
    parameter int unsigned SEC_BASE   = 'h170,
    parameter int unsigned SEC_ALT    = 'h376
) (
    input  logic [1:0]        space,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strobe,
    input  map_e              map_mode,
    output logic              sel,
    output logic [TF_W-1:0]   idx
);
    localparam int unsigned N_LEG  = 2;
    localparam int unsigned HI_W   = ADDR_W - MIRROR_BIT;

    logic             mem_low_hit;
    logic             mem_mir_hit;
    logic [N_LEG-1:0] leg_hit;
    logic [TF_W-1:0]  leg_idx [N_LEG];

    // Low common-memory window: offsets 0x0..0xF.
    always_comb begin
        mem_low_hit = (addr[ADDR_W-1:TF_W] == '0);
    end

    // Mirror window variant chosen by parameter.
    generate
        if (MIRROR_EN) begin : g_mirror
            always_comb begin
                mem_mir_hit = (addr[ADDR_W-1:MIRROR_BIT] == HI_W'(1));
            end
        end else begin : g_nomirror
            always_comb begin
                mem_mir_hit = 1'b0;
            end
        end
    endgenerate

    // One legacy port-set matcher per I/O layout.
    generate
        for (genvar g = 0; g < N_LEG; g++) begin : g_leg
            localparam logic [ADDR_W-1:0] BASE = ADDR_W'((g == 0) ? PRI_BASE : SEC_BASE);
            localparam logic [ADDR_W-1:0] ALT  = ADDR_W'((g == 0) ? PRI_ALT  : SEC_ALT);
            logic base_hit;
            logic alt_hit;
            // Match the eight-port block and the alternate pair.
            always_comb begin
                base_hit   = (addr[ADDR_W-1:3] == BASE[ADDR_W-1:3]);
                alt_hit    = (addr[ADDR_W-1:1] == ALT[ADDR_W-1:1]);
                leg_hit[g] = base_hit || alt_hit;
                if (base_hit)      leg_idx[g] = {1'b0, addr[2:0]};
                else if (alt_hit)  leg_idx[g] = {3'b111, addr[0]};
                else               leg_idx[g] = '0;
            end
        end
    endgenerate

    // Layout select: combine the window hits for the active mode.
    always_comb begin
        sel = 1'b0;
        idx = '0;
        if (strobe) begin
            unique case (map_mode)
                MAP_MEM: begin
                    if (space == SP_COMMON && (mem_low_hit || mem_mir_hit)) begin
                        sel = 1'b1;
                        idx = addr[TF_W-1:0];
                    end
                end
                MAP_CONTIG: begin
                    if (space == SP_IO) begin
                        sel = 1'b1;
                        idx = addr[TF_W-1:0];
                    end
                end
                MAP_PRI: begin
                    if (space == SP_IO && leg_hit[0]) begin
                        sel = 1'b1;
                        idx = leg_idx[0];
                    end
                end
                MAP_SEC: begin
                    if (space == SP_IO && leg_hit[1]) begin
                        sel = 1'b1;
                        idx = leg_idx[1];
                    end
                end
                default: begin
                    sel = 1'b0;
                    idx = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/cfgdec_irq_shape.sv
// Interrupt shaper: registered copy of the request in level mode, a one-clock
// pulse per rising request edge in pulse mode; silenced while the core is held.
module cfgdec_irq_shape (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic level,
    input  logic req,
    output logic irq
);
    logic req_q;

    // Request history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req;
    end

    // Output register: level copy or edge pulse, zero under hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     irq <= 1'b0;
        else if (hold)  irq <= 1'b0;
        else if (level) irq <= req;
        else            irq <= req && !req_q;
    end

endmodule

// File: rtl/cfg_option_decoder.sv
// Top level: configuration option byte, task-file decoder and interrupt shaper.
// Assumes one host access at a time with the space qualifier valid alongside the strobes.
module cfg_option_decoder
    import cfgdec_pkg::*;
#(
    parameter int unsigned ADDR_W     = 11,
    parameter int unsigned CFG_ADDR   = 'h200,
    parameter int unsigned MIRROR_BIT = 10,
    parameter bit          MIRROR_EN  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_space,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    input  logic              host_we,
    input  logic              host_re,
    output logic [7:0]        host_rdata,
    output logic              host_rd_hit,
    input  logic              irq_req,
    output logic              soft_rst,
    output logic              level_mode,
    output logic              irq_out,
    output logic              tf_sel,
    output logic [3:0]        tf_idx
);
    map_e map_mode;
    logic strobe;

    // Any host access strobe.
    always_comb begin
        strobe = host_we || host_re;
    end

    cfgdec_opt_reg #(
        .ADDR_W   (ADDR_W),
        .CFG_ADDR (CFG_ADDR)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .space     (host_space),
        .addr      (host_addr),
        .wdata     (host_wdata),
        .we        (host_we),
        .re        (host_re),
        .rdata     (host_rdata),
        .rd_hit    (host_rd_hit),
        .hold_rst  (soft_rst),
        .level_sel (level_mode),
        .map_mode  (map_mode)
    );

    cfgdec_tf_decode #(
        .ADDR_W     (ADDR_W),
        .MIRROR_BIT (MIRROR_BIT),
        .MIRROR_EN  (MIRROR_EN)
    ) u_dec (
        .space    (host_space),
        .addr     (host_addr),
        .strobe   (strobe),
        .map_mode (map_mode),
        .sel      (tf_sel),
        .idx      (tf_idx)
    );

    cfgdec_irq_shape u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (soft_rst),
        .level (level_mode),
        .req   (irq_req),
        .irq   (irq_out)
    );

endmodule

// File: rtl/cfgdec_checker.sv
// Property checker for cfg_option_decoder, attached with bind below.
module cfgdec_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] host_space,
    input logic       host_we,
    input logic       host_re,
    input logic       host_rd_hit,
    input logic       irq_req,
    input logic       soft_rst,
    input logic       level_mode,
    input logic       irq_out,
    input logic       tf_sel,
    input logic [3:0] tf_idx
);
    // R2: a configuration hit needs an attribute read.
    a_r2_hit_attr: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_hit |-> (host_re && host_space == 2'b01));

    // R3: hold stays set unless a write strobe is present.
    a_r3_hold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !host_we) |=> soft_rst);

    // R4: hold implies the interrupt style bit is cleared.
    a_r4_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> !level_mode);

    // R5: level mode copies the request with one clock delay.
    a_r5_level_copy: assert property (@(posedge clk) disable iff (!rst_n)
        $past(level_mode && !soft_rst) |-> (irq_out == $past(irq_req)));

    // R6: a pulse lasts one clock while pulse mode persists.
    a_r6_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !level_mode) |=> (!irq_out || level_mode));

    // R12: select only on a strobe, never in attribute space, index idle otherwise.
    a_r12_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        tf_sel |-> ((host_we || host_re) && host_space != 2'b01));
    a_r12_idle_idx: assert property (@(posedge clk) disable iff (!rst_n)
        !tf_sel |-> (tf_idx == 4'h0));

    // R13: held core gives no interrupt on the following clock.
    a_r13_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !irq_out);

endmodule

bind cfg_option_decoder cfgdec_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_space  (host_space),
    .host_we     (host_we),
    .host_re     (host_re),
    .host_rd_hit (host_rd_hit),
    .irq_req     (irq_req),
    .soft_rst    (soft_rst),
    .level_mode  (level_mode),
    .irq_out     (irq_out),
    .tf_sel      (tf_sel),
    .tf_idx      (tf_idx)
);

// File: tb/test_cfg_option_decoder.sv
module test_cfg_option_decoder;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    host_space = 2'b11;
    logic [AW-1:0] host_addr = '0;
    logic [7:0]    host_wdata = '0;
    logic          host_we = 1'b0;
    logic          host_re = 1'b0;
    logic [7:0]    host_rdata;
    logic          host_rd_hit;
    logic          irq_req = 1'b0;
    logic          soft_rst;
    logic          level_mode;
    logic          irq_out;
    logic          tf_sel;
    logic [3:0]    tf_idx;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cfg_option_decoder i_cfg_option_decoder (
        .clk(clk), .rst_n(rst_n), .host_space(host_space), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_we(host_we), .host_re(host_re),
        .host_rdata(host_rdata), .host_rd_hit(host_rd_hit), .irq_req(irq_req),
        .soft_rst(soft_rst), .level_mode(level_mode), .irq_out(irq_out),
        .tf_sel(tf_sel), .tf_idx(tf_idx)
    );

    task automatic chk(input string req, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic cfg_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_space = 2'b01; host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0; host_space = 2'b11;
    endtask

    task automatic cfg_read(input logic [AW-1:0] a, output logic [7:0] d, output logic hit);
        @(negedge clk);
        host_space = 2'b01; host_addr = a; host_re = 1'b1;
        #1;
        d = host_rdata; hit = host_rd_hit;
        host_re = 1'b0; host_space = 2'b11;
    endtask

    // Vector: {index[23:18], space[17:16], addr[15:5], sel[4], idx[3:0]}
    localparam int NV = 30;
    localparam logic [23:0] VEC [NV] = '{
        {6'd0, 2'b00, 11'h005, 1'b1, 4'h5}, {6'd0, 2'b00, 11'h00F, 1'b1, 4'hF},
        {6'd0, 2'b00, 11'h010, 1'b0, 4'h0}, {6'd0, 2'b00, 11'h3FF, 1'b0, 4'h0},
        {6'd0, 2'b00, 11'h400, 1'b1, 4'h0}, {6'd0, 2'b00, 11'h7FA, 1'b1, 4'hA},
        {6'd0, 2'b10, 11'h005, 1'b0, 4'h0}, {6'd0, 2'b01, 11'h005, 1'b0, 4'h0},
        {6'd1, 2'b10, 11'h123, 1'b1, 4'h3}, {6'd1, 2'b10, 11'h7FF, 1'b1, 4'hF},
        {6'd1, 2'b00, 11'h003, 1'b0, 4'h0}, {6'd2, 2'b10, 11'h1F0, 1'b1, 4'h0},
        {6'd2, 2'b10, 11'h1F7, 1'b1, 4'h7}, {6'd2, 2'b10, 11'h1F8, 1'b0, 4'h0},
        {6'd2, 2'b10, 11'h3F6, 1'b1, 4'hE}, {6'd2, 2'b10, 11'h3F7, 1'b1, 4'hF},
        {6'd2, 2'b10, 11'h3F5, 1'b0, 4'h0}, {6'd2, 2'b10, 11'h170, 1'b0, 4'h0},
        {6'd2, 2'b00, 11'h1F0, 1'b0, 4'h0}, {6'd3, 2'b10, 11'h170, 1'b1, 4'h0},
        {6'd3, 2'b10, 11'h175, 1'b1, 4'h5}, {6'd3, 2'b10, 11'h376, 1'b1, 4'hE},
        {6'd3, 2'b10, 11'h377, 1'b1, 4'hF}, {6'd3, 2'b10, 11'h1F0, 1'b0, 4'h0},
        {6'd3, 2'b10, 11'h178, 1'b0, 4'h0}, {6'd5, 2'b10, 11'h1F0, 1'b0, 4'h0},
        {6'd5, 2'b00, 11'h404, 1'b1, 4'h4}, {6'd63, 2'b10, 11'h003, 1'b0, 4'h0},
        {6'd63, 2'b00, 11'h00C, 1'b1, 4'hC}, {6'd3, 2'b01, 11'h376, 1'b0, 4'h0}
    };

    function automatic string req_of(input logic [5:0] ix);
        case (ix)
            6'd0: return "R7";
            6'd1: return "R8";
            6'd2: return "R9";
            6'd3: return "R10";
            default: return "R11";
        endcase
    endfunction

    initial begin
        #800000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic hit;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cfg_read(11'h200, rd, hit);
        chk("R1 byte", rd, 8'h00);
        chk("R1 soft_rst", soft_rst, 0);
        chk("R1 level_mode", level_mode, 0);
        chk("R1 irq_out", irq_out, 0);

        // Table walk over layouts; R12 covered by strobe and attribute rows
        for (int i = 0; i < NV; i++) begin
            cfg_write(11'h200, {2'b00, VEC[i][23:18]});
            @(negedge clk);
            host_space = VEC[i][17:16]; host_addr = VEC[i][15:5];
            host_re = (i % 2 == 0); host_we = (i % 2 == 1);
            host_wdata = 8'h00;
            if (VEC[i][17:16] == 2'b01) host_we = 1'b0;
            #1;
            chk(req_of(VEC[i][23:18]), tf_sel, VEC[i][4]);
            if (VEC[i][4]) chk(req_of(VEC[i][23:18]), tf_idx, VEC[i][3:0]);
            host_re = 1'b0; host_we = 1'b0;
            #1;
            chk("R12 no strobe", tf_sel, 0);
            host_space = 2'b11;
        end

        // R2: write/read back, other attribute offset ignored
        cfg_write(11'h200, 8'h41);
        cfg_read(11'h200, rd, hit);
        chk("R2 readback", rd, 8'h41);
        chk("R2 hit", hit, 1);
        chk("R5 level bit", level_mode, 1);
        cfg_write(11'h202, 8'hFF);
        cfg_read(11'h202, rd, hit);
        chk("R2 other offset hit", hit, 0);
        chk("R2 other offset data", rd, 8'h00);
        cfg_read(11'h200, rd, hit);
        chk("R2 byte untouched", rd, 8'h41);

        // R4 / R3: hold bit clears the other fields and sticks
        cfg_write(11'h200, 8'hC3);
        cfg_read(11'h200, rd, hit);
        chk("R4 forced default", rd, 8'h80);
        chk("R3 soft_rst set", soft_rst, 1);
        repeat (5) @(negedge clk);
        chk("R3 soft_rst held", soft_rst, 1);
        cfg_write(11'h200, 8'h02);
        cfg_read(11'h200, rd, hit);
        chk("R3 cleared by write", soft_rst, 0);
        chk("R3 byte after clear", rd, 8'h02);
        cfg_write(11'h200, 8'h80);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R3 cleared by hard reset", soft_rst, 0);
        cfg_read(11'h200, rd, hit);
        chk("R1 byte after reset", rd, 8'h00);

        // R5: level mode
        cfg_write(11'h200, 8'h40);
        @(negedge clk); irq_req = 1'b1;
        @(negedge clk); chk("R5 level high", irq_out, 1);
        @(negedge clk); chk("R5 level held", irq_out, 1);
        irq_req = 1'b0;
        @(negedge clk); chk("R5 level low", irq_out, 0);

        // R6: pulse mode
        cfg_write(11'h200, 8'h00);
        @(negedge clk); chk("R6 idle", irq_out, 0);
        irq_req = 1'b1;
        @(negedge clk); chk("R6 pulse", irq_out, 1);
        @(negedge clk); chk("R6 pulse end", irq_out, 0);
        @(negedge clk); chk("R6 no repeat", irq_out, 0);
        irq_req = 1'b0;
        @(negedge clk); irq_req = 1'b1;
        @(negedge clk); chk("R6 second pulse", irq_out, 1);
        irq_req = 1'b0;

        // R13: held core silences the interrupt
        cfg_write(11'h200, 8'hC0);
        @(negedge clk); irq_req = 1'b1;
        @(negedge clk); chk("R13 quiet", irq_out, 0);
        @(negedge clk); chk("R13 still quiet", irq_out, 0);
        irq_req = 1'b0;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule